// File: doc/BRIEF.md
# Display Position Interrupt Unit

This block raises processor interrupts at programmed points of the video raster. It holds four channels. Each channel stores a target line number, a target horizontal count, an enable mask and a sticky status flag. The timing generator pulses a strobe each time it advances to a new half-line and presents that half-line's index. On every strobe that is not marked as skipped, each channel compares the index with its target. A channel that matches latches its status.

Horizontal placement is coarse. A channel's horizontal target only selects the first or the second half of a line. The second half is chosen when the target exceeds the current half-line width. The single interrupt output is a level: it stays high while any channel has both its status and its mask set. Software clears a status through a register write, and a controller-level clear empties every channel.

The block also turns the half-line index and the elapsed tick count into vertical and horizontal beam positions that software can read.

Top module: `disp_pos_irq`

## Requirements
- R1: After reset, channel 0 holds horizontal 430, vertical 263 and mask 1. Channel 1 holds horizontal 1, vertical 1 and mask 1. Channels 2 and 3 are all zero. Every status bit is 0.
- R2: On a clock where `hl_strobe` is 1 and `hl_skip` is 0, a channel's status is set when 1 + floor(`hl_index`/2) equals its vertical target and `hl_index` bit 0 equals (horizontal target > `hl_width`).
- R3: No status is set on a clock where `hl_strobe` is 0 or `hl_skip` is 1.
- R4: A status bit is sticky. It clears only when an upper-half write to its channel carries 0 in data bit 15, or on `soft_clr`. An upper-half write with bit 15 = 1 leaves the status unchanged.
- R5: `irq` is high exactly when some channel has both status and mask set. It follows any register change from the clock edge at which that change is stored.
- R6: `soft_clr` zeroes every field of every channel and leaves `irq` low.
- R7: `vpos` equals 1 + floor(`hl_index`/2).
- R8: `hpos` equals 1 + floor(`hl_width` × `line_ticks` / `hl_ticks`), clamped to the range 1 to 2 × `hl_width`. When `hl_ticks` is 0, the clamp's upper bound applies.
- R9: A match and a clearing write to the same channel in the same clock leave the status set.
- R10: The register layout is as follows. For the upper half (`wr_hi`/`rd_hi` = 1), bit 15 is status, bit 14 is mask and bits 10:0 are the vertical target. For the lower half, bits 10:0 are the horizontal target. All other bits read as 0. `rd_data` reflects `rd_ch`/`rd_hi` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Controller clear of all channels |
| hl_strobe | input | 1 | Half-line advance pulse |
| hl_skip | input | 1 | Suppress comparison for this half-line |
| hl_index | input | 12 | Current half-line index in the frame |
| hl_width | input | 10 | Half-line width in samples |
| line_ticks | input | 16 | Ticks elapsed in the current line |
| hl_ticks | input | 16 | Ticks per half-line |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel written |
| wr_hi | input | 1 | 1 selects the upper half, 0 the lower half |
| wr_data | input | 16 | Write data |
| rd_ch | input | 2 | Channel read |
| rd_hi | input | 1 | Half read |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Combined level interrupt |
| vpos | output | 13 | Vertical beam position |
| hpos | output | 11 | Horizontal beam position |

## Verification
The bench builds the block with its default parameters. These are 11-bit targets, a 10-bit width, 16-bit tick counts and a 12-bit index. With those values the reset targets 430 and 263 fit, and real half-line widths such as 429 can be used. The 16-bit tick count lets the horizontal product overrun twice the width, so the upper clamp can be reached. A behavioural model tracks every channel on each clock, while directed steps hit the following cases:
- the parity boundary at `hl_width`;
- a skipped strobe;
- set-versus-clear contention;
- a zero tick divisor.

// File: rtl/disp_pos_irq.sv
module disp_pos_irq #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 11,
  parameter int HW_W   = 10,
  parameter int TICK_W = 16,
  parameter int IDX_W  = 12,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              hl_strobe,
  input  logic              hl_skip,
  input  logic [IDX_W-1:0]  hl_index,
  input  logic [HW_W-1:0]   hl_width,
  input  logic [TICK_W-1:0] line_ticks,
  input  logic [TICK_W-1:0] hl_ticks,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_hi,
  input  logic [15:0]       wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_hi,
  output logic [15:0]       rd_data,
  output logic              irq,
  output logic [IDX_W:0]    vpos,
  output logic [HW_W:0]     hpos
);
  localparam int CW = (CNT_W > HW_W) ? CNT_W : HW_W;
  localparam int LW = (IDX_W + 1 > CNT_W) ? IDX_W + 1 : CNT_W;
  localparam int PW = HW_W + TICK_W;

  logic [CNT_W-1:0] hcnt [NCH];
  logic [CNT_W-1:0] vcnt [NCH];
  logic             mask [NCH];
  logic             stat [NCH];
  logic [NCH-1:0]   stat_v;
  logic [NCH-1:0]   pend;

  logic             eval;
  logic [IDX_W:0]   line_no;
  logic             unused_bits;

  assign eval        = hl_strobe & ~hl_skip;
  assign line_no     = (IDX_W+1)'(hl_index >> 1) + (IDX_W+1)'(1);
  assign vpos        = line_no;
  assign unused_bits = ^wr_data[13:CNT_W];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [CNT_W-1:0] H_RST = (g == 0) ? CNT_W'(430) : (g == 1) ? CNT_W'(1) : '0;
    localparam logic [CNT_W-1:0] V_RST = (g == 0) ? CNT_W'(263) : (g == 1) ? CNT_W'(1) : '0;
    localparam logic             M_RST = (g < 2);

    logic hit, sel;
    assign hit = eval && (LW'(vcnt[g]) == LW'(line_no))
                      && (hl_index[0] == (CW'(hcnt[g]) > CW'(hl_width)));
    assign sel = wr_en && (wr_ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hcnt[g] <= H_RST;
        vcnt[g] <= V_RST;
        mask[g] <= M_RST;
        stat[g] <= 1'b0;
      end else if (soft_clr) begin
        hcnt[g] <= '0;
        vcnt[g] <= '0;
        mask[g] <= 1'b0;
        stat[g] <= 1'b0;
      end else begin
        if (sel && wr_hi) begin
          vcnt[g] <= wr_data[CNT_W-1:0];
          mask[g] <= wr_data[14];
          if (!wr_data[15]) stat[g] <= 1'b0;
        end
        if (sel && !wr_hi) hcnt[g] <= wr_data[CNT_W-1:0];
        if (hit) stat[g] <= 1'b1;
      end
    end

    assign stat_v[g] = stat[g];
    assign pend[g]   = stat[g] & mask[g];
  end

  assign irq = |pend;

  always_comb begin
    if (rd_hi) begin
      rd_data = '0;
      rd_data[15] = stat[rd_ch];
      rd_data[14] = mask[rd_ch];
      rd_data[CNT_W-1:0] = vcnt[rd_ch];
    end else begin
      rd_data = '0;
      rd_data[CNT_W-1:0] = hcnt[rd_ch];
    end
  end

  logic [PW-1:0] prod, quo;
  logic [PW:0]   raw;
  logic [HW_W:0] top;

  assign prod = PW'(hl_width) * PW'(line_ticks);
  assign quo  = (hl_ticks == '0) ? '1 : prod / PW'(hl_ticks);
  assign raw  = (PW+1)'(quo) + (PW+1)'(1);
  assign top  = {hl_width, 1'b0};

  always_comb begin
    if (raw > (PW+1)'(top)) hpos = top;
    else                    hpos = raw[HW_W:0];
    if (hpos == '0)         hpos = (HW_W+1)'(1);
  end
endmodule

module disp_pos_irq_chk #(
  parameter int NCH  = 4,
  parameter int CH_W = 2,
  parameter int HW_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_clr,
  input logic            hl_strobe,
  input logic            hl_skip,
  input logic            wr_en,
  input logic [CH_W-1:0] wr_ch,
  input logic            wr_hi,
  input logic [15:0]     wr_data,
  input logic            irq,
  input logic [HW_W:0]   hpos,
  input logic [HW_W-1:0] hl_width,
  input logic [NCH-1:0]  st
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[g]) |-> $past(hl_strobe && !hl_skip)); // R3
    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st[g]) |-> $past(soft_clr || (wr_en && wr_hi && wr_ch == CH_W'(g) && !wr_data[15]))); // R4
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_clr) |-> (st == '0 && !irq)); // R6

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st != '0)); // R5

  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != '0) && (hl_width == '0 || hpos <= {hl_width, 1'b0})); // R8
endmodule

bind disp_pos_irq disp_pos_irq_chk #(.NCH(NCH), .CH_W(CH_W), .HW_W(HW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hl_strobe(hl_strobe),
  .hl_skip(hl_skip), .wr_en(wr_en), .wr_ch(wr_ch), .wr_hi(wr_hi),
  .wr_data(wr_data), .irq(irq), .hpos(hpos), .hl_width(hl_width), .st(stat_v)
);

// File: tb/disp_pos_irq_test.sv
`timescale 1ns/1ps
module disp_pos_irq_test;
  logic clk = 0, rst_n = 0, soft_clr = 0, hl_strobe = 0, hl_skip = 0;
  logic [11:0] hl_index = 0;
  logic [9:0]  hl_width = 429;
  logic [15:0] line_ticks = 0, hl_ticks = 1000;
  logic        wr_en = 0, wr_hi = 0, rd_hi = 0;
  logic [1:0]  wr_ch = 0, rd_ch = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        irq;
  logic [12:0] vpos;
  logic [10:0] hpos;

  int checks = 0, errors = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  disp_pos_irq uut (.*);

  int mh[4], mv[4];
  bit mm[4], ms[4];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int hp(int w, int t, int h);
    longint q, v;
    q = (h == 0) ? 64'h7fffffff : (longint'(w) * t) / h;
    v = q + 1;
    if (v > 2 * w) v = 2 * w;
    if (v < 1) v = 1;
    return int'(v);
  endfunction

  function automatic int mread(int c, bit hi);
    return hi ? ((int'(ms[c]) << 15) | (int'(mm[c]) << 14) | mv[c]) : mh[c];
  endfunction

  always @(posedge clk) begin
    bit hit[4];
    if (!rst_n) begin
      mh = '{430, 1, 0, 0}; mv = '{263, 1, 0, 0};
      mm = '{1, 1, 0, 0};   ms = '{0, 0, 0, 0};
    end else if (soft_clr) begin
      mh = '{0, 0, 0, 0}; mv = '{0, 0, 0, 0};
      mm = '{0, 0, 0, 0}; ms = '{0, 0, 0, 0};
    end else begin
      for (int c = 0; c < 4; c++)
        hit[c] = hl_strobe && !hl_skip && (1 + hl_index / 2 == mv[c]) &&
                 ((hl_index % 2) == ((mh[c] > hl_width) ? 1 : 0));
      if (wr_en && wr_hi) begin
        mv[wr_ch] = wr_data[10:0];
        mm[wr_ch] = wr_data[14];
        if (!wr_data[15]) ms[wr_ch] = 0;
      end
      if (wr_en && !wr_hi) mh[wr_ch] = wr_data[10:0];
      for (int c = 0; c < 4; c++) if (hit[c]) ms[c] = 1;
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R5 irq model", irq, (ms[0]&&mm[0])||(ms[1]&&mm[1])||(ms[2]&&mm[2])||(ms[3]&&mm[3]));
      chk("R7 vpos model", vpos, 1 + hl_index / 2);
      chk("R8 hpos model", hpos, hp(hl_width, line_ticks, hl_ticks));
      chk("R10 rd_data model", rd_data, mread(rd_ch, rd_hi));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int ch, bit hi, int data);
    wr_en = 1; wr_ch = 2'(ch); wr_hi = hi; wr_data = 16'(data);
    step();
    wr_en = 0;
  endtask

  task automatic strobe(int idx, bit skip);
    hl_strobe = 1; hl_skip = skip; hl_index = 12'(idx);
    step();
    hl_strobe = 0; hl_skip = 0;
  endtask

  task automatic rdc(int ch, bit hi, int exp, string tag);
    rd_ch = 2'(ch); rd_hi = hi; #0.5;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; running = 1;
    step();
    // R1 and R10: reset contents through the read port
    rdc(0, 1, 'h4107, "R1 ch0 hi"); rdc(0, 0, 430, "R1 ch0 lo");
    rdc(1, 1, 'h4001, "R1 ch1 hi"); rdc(1, 0, 1, "R1 ch1 lo");
    rdc(2, 1, 0, "R1 ch2 hi");      rdc(3, 0, 0, "R1 ch3 lo");
    chk("R1 irq low", irq, 0);

    // R2: line matches but parity does not
    strobe(524, 0);
    rdc(0, 1, 'h4107, "R2 wrong parity");
    chk("R2 irq low", irq, 0);
    hl_index = 525; #0.5;
    chk("R7 vpos 525", vpos, 263);
    strobe(525, 0);
    rdc(0, 1, 'hC107, "R2 match second half");
    chk("R5 irq high", irq, 1);

    // R3: skipped and absent strobes
    strobe(0, 1);
    rdc(1, 1, 'h4001, "R3 skipped");
    hl_index = 0; step();
    rdc(1, 1, 'h4001, "R3 no strobe");
    strobe(0, 0);
    rdc(1, 1, 'hC001, "R2 match first half");

    // R4: sticky status
    wr(0, 1, 'hC107);
    rdc(0, 1, 'hC107, "R4 write one keeps");
    wr(1, 1, 'h4001);
    rdc(1, 1, 'h4001, "R4 write zero clears");
    chk("R5 irq from ch0", irq, 1);

    // R5: mask gating
    wr(0, 1, 'h8107);
    chk("R5 masked irq low", irq, 0);
    rdc(0, 1, 'h8107, "R5 status kept when masked");
    wr(0, 1, 'hC107);
    chk("R5 unmask irq high", irq, 1);
    wr(0, 1, 'h4107);
    chk("R5 cleared irq low", irq, 0);

    // R9: set beats clear in the same clock
    wr(2, 0, 0);
    wr(2, 1, 'h4005);
    wr_en = 1; wr_ch = 2; wr_hi = 1; wr_data = 'h4005;
    strobe(8, 0);
    wr_en = 0;
    rdc(2, 1, 'hC005, "R9 set wins");
    chk("R9 irq", irq, 1);

    // R6: controller clear
    soft_clr = 1; step(); soft_clr = 0;
    rdc(0, 1, 0, "R6 ch0 hi");
    rdc(2, 1, 0, "R6 ch2 hi");
    chk("R6 irq low", irq, 0);

    // R8: horizontal position and clamps
    hl_width = 429; hl_ticks = 1000; line_ticks = 500; #0.5;
    chk("R8 mid", hpos, 215);
    line_ticks = 2500; #0.5;
    chk("R8 upper clamp", hpos, 858);
    line_ticks = 0; #0.5;
    chk("R8 lower", hpos, 1);
    hl_ticks = 0; line_ticks = 10; #0.5;
    chk("R8 zero divisor", hpos, 858);
    hl_width = 0; hl_ticks = 700; #0.5;
    chk("R8 zero width", hpos, 1);
    step();

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      hl_width   = 10'($urandom_range(0, 40));
      line_ticks = 16'($urandom);
      hl_ticks   = 16'($urandom_range(0, 3000));
      hl_strobe  = ($urandom_range(0, 2) != 0);
      hl_skip    = ($urandom_range(0, 5) == 0);
      hl_index   = 12'($urandom_range(0, 24));
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_ch      = 2'($urandom);
      wr_hi      = 1'($urandom);
      wr_data    = wr_hi ? 16'(($urandom & 'hC000) | $urandom_range(0, 12))
                         : 16'($urandom_range(0, 50));
      soft_clr   = ($urandom_range(0, 150) == 0);
      rd_ch      = 2'($urandom);
      rd_hi      = 1'($urandom);
      step();
    end
    hl_strobe = 0; wr_en = 0; soft_clr = 0;
    step(); step();
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule